// File: doc/BRIEF.md
# Broadcast Constant-Read Serializer

This block serves one read request from a 32-lane group against a read-only constant space of 64 KiB, addressed as 16K words of 32 bits. Each lane brings an enable bit and a 14-bit word address. The request is worked off in two 16-lane halves: the low half (lanes 0 to 15) first, then the high half (lanes 16 to 31).

Within a half, the block finds the distinct addresses among the enabled lanes. It performs one lookup per distinct address. Each returned word goes to every lane of that half that named the same address. So when all lanes of a half share one address, the half costs a single lookup, while sixteen different addresses cost sixteen.

Lookups go to a 16-line direct-mapped cache that holds one word per line. A miss sends a single-cycle request to a backing memory and waits for its response, which arrives a fixed number of cycles later. The line is filled on that response. Two free-running counters expose the number of lookups and the number of misses.

The request side and the response side are both valid/ready streams. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the response has been taken. The response holds `rsp_valid` and every lane word unchanged until it is taken on an edge where `rsp_ready` is high.

Top module: `cbs_serializer`

## Requirements
- R1: `req_ready` is high only when the block is idle. It is low from the edge that takes a request until the edge that takes the response. `rsp_valid` and `rsp_data` hold steady while `rsp_ready` is low.
- R2: In the response, the 32-bit field `rsp_data[32*i +: 32]` of an enabled lane i holds the backing-memory word at that lane's address. The field of a disabled lane holds zero.
- R3: A request makes exactly d0 + d1 lookups. Here d0 is the number of distinct addresses among the enabled lanes 0..15, and d1 is the same count for lanes 16..31. `lookup_count` rises by one per lookup.
- R4: A half whose enabled lanes all share one address costs one lookup. A half with no enabled lanes costs zero lookups.
- R5: Distinct addresses of a half are looked up in ascending order of the lowest lane that names each one. The low half finishes before the high half starts.
- R6: When every lookup of a request hits, `rsp_valid` rises d0 + d1 + 2 clock edges after the edge that took the request.
- R7: A miss raises `mem_req_valid` for exactly one cycle with the word address on `mem_req_addr`. The block then waits for `mem_rsp_valid`, fills the line and increments `miss_count`. `miss_count` never rises without `lookup_count` rising on the same edge.
- R8: The cache is direct-mapped with 16 lines. The line index is address bits [3:0], and the tag is address bits [13:4], compared in full. An address evicts any other address with the same index.
- R9: After reset, every cache line is invalid, both counters are zero, `req_ready` is high, and `rsp_valid` and `mem_req_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, able to take a request |
| req_lane_en | input | 32 | Per-lane enable |
| req_lane_addr | input | 448 | Lane i word address at [14*i +: 14] |
| rsp_valid | output | 1 | All 32 lane words ready |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | 1024 | Lane i word at [32*i +: 32] |
| mem_req_valid | output | 1 | One-cycle backing-memory read request |
| mem_req_addr | output | 14 | Word address of the backing read |
| mem_rsp_valid | input | 1 | Backing-memory word present |
| mem_rsp_data | input | 32 | Backing-memory word |
| lookup_count | output | 32 | Lookups issued since reset |
| miss_count | output | 32 | Lookups that missed since reset |

## Verification
The bench counts clock edges from the edge that takes a request. For requests whose lookups all hit, it expects `rsp_valid` at d0 + d1 + 2 edges. For requests with misses, it waits on `rsp_valid` and checks only the lane words and the counters.

`req_ready` is sampled on the first falling edge after acceptance. Lane words and counter deltas are sampled at a falling edge while the response is held. On some requests `rsp_ready` is held low for a few cycles, and the response is re-sampled each cycle to confirm it holds. `req_ready` is checked on the falling edge after the response is taken.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_FETCH,
    ST_WAIT,
    ST_DONE
  } cbs_state_e;
endpackage

// File: rtl/cbs_pick.sv
// Finds the lowest pending lane of a half and every pending lane sharing its address.
module cbs_pick #(
  parameter int HALF   = 16,
  parameter int ADDR_W = 14
) (
  input  logic [HALF*ADDR_W-1:0] half_addr,
  input  logic [HALF-1:0]        pending,
  output logic                   any,
  output logic [ADDR_W-1:0]      sel_addr,
  output logic [HALF-1:0]        match
);
  always_comb begin
    any      = 1'b0;
    sel_addr = '0;
    for (int j = HALF - 1; j >= 0; j--) begin
      if (pending[j]) begin
        any      = 1'b1;
        sel_addr = half_addr[j*ADDR_W +: ADDR_W];
      end
    end
    for (int j = 0; j < HALF; j++) begin
      match[j] = pending[j] && (half_addr[j*ADDR_W +: ADDR_W] == sel_addr);
    end
  end
endmodule

// File: rtl/cbs_cache.sv
// Direct-mapped, one word per line, filled on miss.
module cbs_cache #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int LINES  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              hit,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [DATA_W-1:0] fill_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0] line_ok;
  logic [TAG_W-1:0] line_tag [LINES];
  logic [DATA_W-1:0] line_word [LINES];

  logic [IDX_W-1:0] rd_idx, fl_idx;
  assign rd_idx = rd_addr[IDX_W-1:0];
  assign fl_idx = fill_addr[IDX_W-1:0];

  assign hit     = line_ok[rd_idx] && (line_tag[rd_idx] == rd_addr[ADDR_W-1:IDX_W]);
  assign rd_data = line_word[rd_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_ok <= '0;
      for (int k = 0; k < LINES; k++) begin
        line_tag[k]  <= '0;
        line_word[k] <= '0;
      end
    end else if (fill_en) begin
      line_ok[fl_idx]   <= 1'b1;
      line_tag[fl_idx]  <= fill_addr[ADDR_W-1:IDX_W];
      line_word[fl_idx] <= fill_data;
    end
  end
endmodule

// File: rtl/cbs_serializer.sv
module cbs_serializer #(
  parameter int LANES  = 32,
  parameter int ADDR_W = 14,
  parameter int DATA_W = 32,
  parameter int LINES  = 16,
  parameter int CNT_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        req_lane_en,
  input  logic [LANES*ADDR_W-1:0] req_lane_addr,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [LANES*DATA_W-1:0] rsp_data,
  output logic                    mem_req_valid,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [DATA_W-1:0]       mem_rsp_data,
  output logic [CNT_W-1:0]        lookup_count,
  output logic [CNT_W-1:0]        miss_count
);
  import cbs_pkg::*;
  localparam int HALF = LANES / 2;

  cbs_state_e state;
  logic                    upper;
  logic [HALF-1:0]         pending;
  logic [LANES-1:0]        en_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]       word_q [LANES];

  logic [HALF*ADDR_W-1:0] half_addr;
  logic                   any;
  logic [ADDR_W-1:0]      sel_addr;
  logic [HALF-1:0]        match;
  logic                   hit;
  logic [DATA_W-1:0]      hit_data;
  logic                   fill_en;
  logic                   wr_en;
  logic [DATA_W-1:0]      wr_word;

  assign half_addr = upper ? addr_q[LANES*ADDR_W-1 : HALF*ADDR_W]
                           : addr_q[HALF*ADDR_W-1 : 0];

  cbs_pick #(.HALF(HALF), .ADDR_W(ADDR_W)) pick_i (
    .half_addr(half_addr), .pending(pending),
    .any(any), .sel_addr(sel_addr), .match(match)
  );

  assign fill_en = (state == ST_WAIT) && mem_rsp_valid;

  cbs_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES)) cache_i (
    .clk(clk), .rst_n(rst_n),
    .rd_addr(sel_addr), .hit(hit), .rd_data(hit_data),
    .fill_en(fill_en), .fill_addr(sel_addr), .fill_data(mem_rsp_data)
  );

  assign wr_en   = ((state == ST_SCAN) && any && hit) || fill_en;
  assign wr_word = fill_en ? mem_rsp_data : hit_data;

  assign req_ready     = (state == ST_IDLE);
  assign rsp_valid     = (state == ST_DONE);
  assign mem_req_valid = (state == ST_FETCH);
  assign mem_req_addr  = sel_addr;

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign rsp_data[g*DATA_W +: DATA_W] = word_q[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      upper        <= 1'b0;
      pending      <= '0;
      en_q         <= '0;
      addr_q       <= '0;
      lookup_count <= '0;
      miss_count   <= '0;
      for (int k = 0; k < LANES; k++) word_q[k] <= '0;
    end else begin
      if (wr_en) begin
        for (int j = 0; j < HALF; j++) begin
          if (match[j]) word_q[j + (upper ? HALF : 0)] <= wr_word;
        end
      end
      case (state)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_lane_addr;
          en_q    <= req_lane_en;
          upper   <= 1'b0;
          pending <= req_lane_en[HALF-1:0];
          for (int k = 0; k < LANES; k++) word_q[k] <= '0;
          state   <= ST_SCAN;
        end
        ST_SCAN: begin
          if (!any) begin
            if (!upper) begin
              upper   <= 1'b1;
              pending <= en_q[LANES-1:HALF];
            end else begin
              state <= ST_DONE;
            end
          end else begin
            lookup_count <= lookup_count + 1'b1;
            if (hit) begin
              pending <= pending & ~match;
            end else begin
              miss_count <= miss_count + 1'b1;
              state      <= ST_FETCH;
            end
          end
        end
        ST_FETCH: state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          pending <= pending & ~match;
          state   <= ST_SCAN;
        end
        ST_DONE: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cbs_serializer_chk.sv
module cbs_serializer_chk #(
  parameter int LANES  = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_ready,
  input logic                    rsp_valid,
  input logic                    rsp_ready,
  input logic [LANES*DATA_W-1:0] rsp_data,
  input logic                    mem_req_valid,
  input logic [CNT_W-1:0]        lookup_count,
  input logic [CNT_W-1:0]        miss_count
);
  // R1
  ready_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (rsp_valid || mem_req_valid)));

  // R1
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R1
  rsp_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ready) |=> (req_ready && !rsp_valid));

  // R3
  lookup_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lookup_count == $past(lookup_count)) || (lookup_count == $past(lookup_count) + 1));

  // R7
  miss_with_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_count != $past(miss_count)) |-> (lookup_count == $past(lookup_count) + 1));

  // R7
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |=> !mem_req_valid);
endmodule

bind cbs_serializer cbs_serializer_chk #(
  .LANES(LANES), .DATA_W(DATA_W), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_data(rsp_data), .mem_req_valid(mem_req_valid),
  .lookup_count(lookup_count), .miss_count(miss_count)
);

// File: tb/cbs_serializer_tb_top.sv
`timescale 1ns/1ps
module cbs_serializer_tb_top;
  localparam int LANES = 32;
  localparam int AW    = 14;
  localparam int DW    = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [LANES-1:0]   req_lane_en = '0;
  logic [LANES*AW-1:0] req_lane_addr = '0;
  logic               rsp_valid;
  logic               rsp_ready = 1'b0;
  logic [LANES*DW-1:0] rsp_data;
  logic               mem_req_valid;
  logic [AW-1:0]      mem_req_addr;
  logic               mem_rsp_valid;
  logic [DW-1:0]      mem_rsp_data;
  logic [31:0]        lookup_count, miss_count;

  cbs_serializer dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_lane_en(req_lane_en), .req_lane_addr(req_lane_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .lookup_count(lookup_count), .miss_count(miss_count)
  );

  function automatic logic [DW-1:0] mem_word(input logic [AW-1:0] a);
    return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A0F0F;
  endfunction

  // backing memory: fixed three-cycle latency
  logic [2:0]    pv;
  logic [AW-1:0] pa0, pa1, pa2;
  always @(posedge clk) begin
    if (!rst_n) pv <= '0;
    else        pv <= {pv[1:0], mem_req_valid};
    pa0 <= mem_req_addr; pa1 <= pa0; pa2 <= pa1;
  end
  assign mem_rsp_valid = pv[2];
  assign mem_rsp_data  = mem_word(pa2);

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // bench reference cache
  bit          m_ok  [16];
  logic [9:0]  m_tag [16];
  logic [AW-1:0] a [LANES];
  logic [31:0] prev_lk = 0, prev_ms = 0;

  task automatic do_req(input logic [LANES-1:0] en, input int hold);
    int exp_lk = 0, exp_ms = 0, cyc = 0;
    logic [DW-1:0] exp_w [LANES];
    logic [LANES*DW-1:0] snap;
    for (int h = 0; h < 2; h++) begin
      for (int i = h*16; i < h*16 + 16; i++) begin
        bit seen = 0;
        for (int k = h*16; k < i; k++) if (en[k] && a[k] == a[i]) seen = 1;
        if (en[i] && !seen) begin
          exp_lk++;
          if (!(m_ok[a[i][3:0]] && m_tag[a[i][3:0]] == a[i][13:4])) begin
            exp_ms++;
            m_ok[a[i][3:0]]  = 1;
            m_tag[a[i][3:0]] = a[i][13:4];
          end
        end
      end
    end
    for (int i = 0; i < LANES; i++) exp_w[i] = en[i] ? mem_word(a[i]) : '0;
    @(negedge clk);
    req_valid   = 1'b1;
    req_lane_en = en;
    for (int i = 0; i < LANES; i++) req_lane_addr[i*AW +: AW] = a[i];
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R1", "ready low while busy", req_ready, 0);
    while (!rsp_valid && cyc < 5000) begin
      @(posedge clk); cyc++; @(negedge clk);
    end
    if (exp_ms == 0)
      chk(cyc == exp_lk + 2, "R6", "all-hit latency", cyc, exp_lk + 2);
    chk(lookup_count - prev_lk == exp_lk, "R3", "lookups", lookup_count - prev_lk, exp_lk);
    chk(miss_count - prev_ms == exp_ms, "R8", "misses", miss_count - prev_ms, exp_ms);
    begin
      int bad = -1;
      for (int i = 0; i < LANES; i++)
        if (bad < 0 && rsp_data[i*DW +: DW] !== exp_w[i]) bad = i;
      if (bad < 0) chk(1, "R2", "lane data", 0, 0);
      else chk(0, "R2", $sformatf("lane %0d data", bad), rsp_data[bad*DW +: DW], exp_w[bad]);
    end
    snap = rsp_data;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == snap, "R1", "response held", rsp_valid, 1);
    end
    prev_lk = lookup_count;
    prev_ms = miss_count;
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R1", "released after take", {rsp_valid, req_ready}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'h1234));
    for (int i = 0; i < 16; i++) m_ok[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R9", "idle after reset",
        {req_ready, rsp_valid, mem_req_valid}, 3'b100);
    chk(lookup_count == 0 && miss_count == 0, "R9", "counters zero",
        {lookup_count, miss_count}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready out of reset", req_ready, 1);

    // R4: one shared address per half, cold then warm
    for (int i = 0; i < LANES; i++) a[i] = (i < 16) ? 14'h0123 : 14'h0456;
    do_req('1, 0);
    do_req('1, 2);
    // R4: empty request, zero lookups, latency 2
    do_req('0, 0);
    // R5: low half only, high half idle
    for (int i = 0; i < LANES; i++) a[i] = 14'h0123;
    do_req(32'h0000_FFFF, 0);
    // R3: sixteen distinct per half
    for (int i = 0; i < LANES; i++) a[i] = 14'(14'h0200 + i);
    do_req('1, 0);
    do_req('1, 1);
    // R8 / R5: full-width tag conflict inside one half; order decides misses
    for (int i = 0; i < LANES; i++) a[i] = 14'h0005;
    a[3] = 14'h3FF5;
    do_req(32'h0000_00FF, 0);
    do_req(32'h0000_00FF, 0);
    a[0] = 14'h3FF5; a[3] = 14'h0005;
    do_req(32'h0000_00FF, 0);

    // random mix from small pools
    for (int n = 0; n < 60; n++) begin
      int pool = 1 + ($urandom % 24);
      logic [AW-1:0] base = 14'($urandom);
      for (int i = 0; i < LANES; i++) a[i] = 14'(base + ($urandom % pool) * (($urandom % 2) ? 1 : 16));
      do_req($urandom, $urandom % 3);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule